// File: doc/BRIEF.md
# Dual Prescaled Reference Timer

This block holds two independent 16-bit up-counters reached through a single-cycle register port. Each counter advances on a tick. The tick comes from a clock path with three stages: a source select that picks the core clock, the core clock divided by a fixed sixteen, or no source. A primary 8-bit divider and a secondary 8-bit divider follow. When a tick arrives while the counter equals its reference value, the timer latches a match event. It can then restart from zero or keep counting. An interrupt line is driven while the event is pending and its enable is set.

One shared control byte holds a release bit and a freeze bit for each timer. Software holds a timer in its zero state, loads mode, dividers, reference and an optional counter preload, clears stale events, and then releases and unfreezes the timer. Events are acknowledged by writing ones to the event register.

Top module: `gpt_pair`

## Requirements
- R1: After reset every counter reads 0, the control byte (address 0x0) reads 0, the mode registers read 0 and both interrupt lines are low.
- R2: With mode bits 2:1 = 01 (core clock), primary value P (register at field 5) and secondary value S (mode bits 15:8), the counter advances once every (P+1)×(S+1) cycles, and the first advance comes one full period after the timer starts.
- R3: With mode bits 2:1 = 10, the period is 16×(P+1)×(S+1) cycles.
- R4: With mode bit 3 set, a tick that finds the counter equal to the reference returns the counter to 0.
- R5: With mode bit 3 clear, the counter keeps incrementing past the reference and wraps from 0xFFFF to 0x0000.
- R6: A tick that finds the counter equal to the reference sets event bit 1 (field 4). Writing a 1 to that bit clears it, and writing 0 leaves it set.
- R7: If a match and a clearing write to event bit 1 fall in the same cycle, the bit stays set.
- R8: Interrupt line t is high exactly while timer t's event bit 1 and its mode bit 4 are both 1.
- R9: Timer 0 uses control bits 0 (release) and 1 (freeze), and timer 1 uses bits 4 and 5. While its release bit is 0, a timer holds its counter and dividers at zero, even against a counter write.
- R10: While the freeze bit is 1, the counter and dividers keep their values.
- R11: A write to the counter field (field 3) of a released timer loads the written value.
- R12: With mode bits 2:1 = 00, no external source exists, so the counter does not advance.

Register address is {timer, field[2:0]}, with timer in bit 3. The fields are 1 mode, 2 reference, 3 counter, 4 event and 5 primary divider. The control byte lives at address 0x0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address {timer, field} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-timer match interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit counters, 8-bit dividers and a fixed slow divide of sixteen. It keeps the programmed divider values small, so every divide path and restart pattern completes many periods within a few hundred cycles. The wrap from 0xFFFF becomes reachable by preloading the counter near the top instead of waiting 65536 ticks. The dividers at their full 8-bit range are the values left unexplored.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [2:0] {
    FLD_CTRL = 3'd0,
    FLD_MODE = 3'd1,
    FLD_REF  = 3'd2,
    FLD_CNT  = 3'd3,
    FLD_EVT  = 3'd4,
    FLD_PSC  = 3'd5
  } fld_e;

  typedef enum logic [1:0] {
    SRC_CASCADE = 2'b00,
    SRC_INT     = 2'b01,
    SRC_SLOW    = 2'b10,
    SRC_NONE    = 2'b11
  } src_e;

  localparam int MODE_SRC_LSB     = 1;
  localparam int MODE_RESTART_BIT = 3;
  localparam int MODE_IE_BIT      = 4;
  localparam int MODE_SEC_LSB     = 8;
  localparam int EVT_REF_BIT      = 1;
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale
  import gpt_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             reload,
  input  logic             run,
  input  logic [1:0]       src,
  input  logic [PRE_W-1:0] pri,
  input  logic [PRE_W-1:0] sec,
  output logic             tick
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [SW-1:0]    slow_q, slow_d;
  logic [PRE_W-1:0] p_q, p_d, s_q, s_d;
  logic             base_en, p_wrap, s_wrap, zero;

  always_comb begin
    zero    = hold | reload;
    base_en = run && ((src == SRC_INT) || ((src == SRC_SLOW) && (slow_q == SLOW_LAST)));
    p_wrap  = (p_q == pri);
    s_wrap  = (s_q == sec);
    tick    = base_en && p_wrap && s_wrap;
    slow_d  = slow_q;
    p_d     = p_q;
    s_d     = s_q;
    if (zero) begin
      slow_d = '0;
      p_d    = '0;
      s_d    = '0;
    end else begin
      if (run && (src == SRC_SLOW)) slow_d = (slow_q == SLOW_LAST) ? '0 : slow_q + 1'b1;
      if (base_en) begin
        p_d = p_wrap ? '0 : p_q + 1'b1;
        if (p_wrap) s_d = s_wrap ? '0 : s_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      p_q    <= '0;
      s_q    <= '0;
    end else begin
      slow_q <= slow_d;
      p_q    <= p_d;
      s_q    <= s_d;
    end
  end

  // R10
  prescale_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !zero) |=> ($stable(p_q) && $stable(s_q)));

  // R2
  prescale_rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !zero) |=> ((p_q == '0) && (s_q == '0)));
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             released,
  input  logic             stop,
  input  logic             we,
  input  logic [2:0]       fld,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  logic [1:0]       src_q, src_d;
  logic             restart_q, restart_d, ie_q, ie_d, evt_q, evt_d;
  logic [PRE_W-1:0] sec_q, sec_d, pri_q, pri_d;
  logic [CNT_W-1:0] ref_q, ref_d, cnt_q, cnt_d;
  logic             hold, run, reload, tick, match;
  logic             wr_mode, wr_ref, wr_cnt, wr_evt, wr_psc;

  gpt_prescale #(.PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_psc (
    .clk(clk), .rst_n(rst_n), .hold(hold), .reload(reload), .run(run),
    .src(src_q), .pri(pri_q), .sec(sec_q), .tick(tick)
  );

  always_comb begin
    hold    = !released;
    run     = released && !stop;
    wr_mode = we && (fld == FLD_MODE);
    wr_ref  = we && (fld == FLD_REF);
    wr_cnt  = we && (fld == FLD_CNT);
    wr_evt  = we && (fld == FLD_EVT);
    wr_psc  = we && (fld == FLD_PSC);
    reload  = wr_mode | wr_psc;
    match   = tick && (cnt_q == ref_q);

    src_d     = wr_mode ? wdata[MODE_SRC_LSB +: 2]     : src_q;
    restart_d = wr_mode ? wdata[MODE_RESTART_BIT]      : restart_q;
    ie_d      = wr_mode ? wdata[MODE_IE_BIT]           : ie_q;
    sec_d     = wr_mode ? wdata[MODE_SEC_LSB +: PRE_W] : sec_q;
    pri_d     = wr_psc  ? wdata[PRE_W-1:0]             : pri_q;
    ref_d     = wr_ref  ? wdata                        : ref_q;

    if (hold)                    cnt_d = '0;
    else if (wr_cnt)             cnt_d = wdata;
    else if (match && restart_q) cnt_d = '0;
    else if (tick)               cnt_d = cnt_q + 1'b1;
    else                         cnt_d = cnt_q;

    evt_d = match | (evt_q & ~(wr_evt & wdata[EVT_REF_BIT]));

    rdata = '0;
    case (fld)
      FLD_MODE: begin
        rdata[MODE_SRC_LSB +: 2]     = src_q;
        rdata[MODE_RESTART_BIT]      = restart_q;
        rdata[MODE_IE_BIT]           = ie_q;
        rdata[MODE_SEC_LSB +: PRE_W] = sec_q;
      end
      FLD_REF: rdata = ref_q;
      FLD_CNT: rdata = cnt_q;
      FLD_EVT: rdata[EVT_REF_BIT] = evt_q;
      FLD_PSC: rdata[PRE_W-1:0] = pri_q;
      default: rdata = '0;
    endcase
    irq = evt_q & ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      restart_q <= 1'b0;
      ie_q      <= 1'b0;
      sec_q     <= '0;
      pri_q     <= '0;
      ref_q     <= '0;
      cnt_q     <= '0;
      evt_q     <= 1'b0;
    end else begin
      src_q     <= src_d;
      restart_q <= restart_d;
      ie_q      <= ie_d;
      sec_q     <= sec_d;
      pri_q     <= pri_d;
      ref_q     <= ref_d;
      cnt_q     <= cnt_d;
      evt_q     <= evt_d;
    end
  end

  // R4
  restart_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && restart_q && released && !wr_cnt) |=> (cnt_q == '0));

  // R5
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart_q && released && !wr_cnt) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> evt_q);

  // R9
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !released |=> (cnt_q == '0));

  // R10
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (released && stop && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: rtl/gpt_pair.sv
module gpt_pair
  import gpt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [1:0]       irq
);
  localparam int NTMR   = 2;
  localparam int CTRL_W = 4 * NTMR;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [2:0]        fld;
  logic              sel;
  logic [CNT_W-1:0]  chan_rd [NTMR];

  always_comb begin
    fld    = bus_addr[2:0];
    sel    = bus_addr[3];
    ctrl_d = (bus_wr && (bus_addr == 4'd0)) ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    if (fld == FLD_CTRL) bus_rdata = sel ? '0 : CNT_W'(ctrl_q);
    else                 bus_rdata = chan_rd[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    logic ch_we;
    assign ch_we = bus_wr && (sel == 1'(t)) && (fld != FLD_CTRL);
    gpt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .released(ctrl_q[4*t]), .stop(ctrl_q[4*t+1]),
      .we(ch_we), .fld(fld), .wdata(bus_wdata),
      .rdata(chan_rd[t]), .irq(irq[t])
    );
  end

  // R9
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr != 4'd0)) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_gpt_pair.sv
`timescale 1ns/1ps
module tb_gpt_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;
  logic [7:0]  ctl = 8'd0;
  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpt_pair dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [16:0] model(int ticks, int c0, int r, bit rs);
    logic [15:0] c = 16'(c0);
    logic e = 1'b0;
    for (int i = 0; i < ticks; i++) begin
      if (c == 16'(r)) begin
        e = 1'b1;
        c = rs ? 16'd0 : c + 16'd1;
      end else c = c + 16'd1;
    end
    return {e, c};
  endfunction

  task automatic setup(int t, logic [1:0] src, int p, int s, int r, int c0, bit rs, bit ie);
    logic [3:0] b = 4'(t * 8);
    ctl[4*t] = 1'b0; ctl[4*t+1] = 1'b1; wr(4'd0, 16'(ctl));
    ctl[4*t] = 1'b1; wr(4'd0, 16'(ctl));
    wr(b + 4'd1, {8'(s), 3'b000, ie, rs, src, 1'b0});
    wr(b + 4'd5, 16'(p));
    wr(b + 4'd2, 16'(r));
    wr(b + 4'd3, 16'(c0));
    wr(b + 4'd4, 16'hFFFF);
  endtask

  task automatic start(int t);
    ctl[4*t+1] = 1'b0;
    wr(4'd0, 16'(ctl));
  endtask

  task automatic trial(string req, int t, bit slow, int p, int s, int r, int c0,
                       bit rs, bit ie, int n);
    logic [15:0] v;
    logic [16:0] e;
    int per;
    setup(t, slow ? 2'b10 : 2'b01, p, s, r, c0, rs, ie);
    start(t);
    repeat (n) @(posedge clk);
    @(negedge clk);
    per = (p + 1) * (s + 1) * (slow ? 16 : 1);
    e = model(n / per, c0, r, rs);
    rd(4'(t * 8 + 3), v);
    check(req, "counter", 32'(v), 32'(e[15:0]));
    rd(4'(t * 8 + 4), v);
    check(req, "event", 32'(v), {30'd0, e[16], 1'b0});
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    rd(4'd3, v);  check("R1", "cnt0", 32'(v), 32'd0);
    rd(4'd11, v); check("R1", "cnt1", 32'(v), 32'd0);
    rd(4'd0, v);  check("R1", "ctrl", 32'(v), 32'd0);
    rd(4'd1, v);  check("R1", "mode", 32'(v), 32'd0);
    check("R1", "irq", 32'(irq), 32'd0);

    wr(4'd3, 16'h1234);
    rd(4'd3, v); check("R9", "held write", 32'(v), 32'd0);

    setup(0, 2'b01, 0, 0, 100, 16'h0ABC, 0, 0);
    rd(4'd3, v); check("R11", "preload", 32'(v), 32'h0ABC);

    setup(0, 2'b00, 0, 0, 100, 7, 0, 0);
    start(0);
    repeat (50) @(posedge clk);
    @(negedge clk);
    rd(4'd3, v); check("R12", "no source", 32'(v), 32'd7);

    trial("R2", 0, 0, 2, 1, 1000, 0, 0, 0, 60);

    ctl[0] = 1'b0; wr(4'd0, 16'(ctl));
    trial("R3", 1, 1, 0, 1, 1000, 0, 0, 0, 100);
    rd(4'd3, v); check("R9", "t0 held by own bit", 32'(v), 32'd0);

    trial("R4", 0, 0, 0, 0, 4, 0, 1, 1, 13);
    check("R8", "irq0 set", 32'(irq[0]), 32'd1);
    check("R8", "irq1 idle", 32'(irq[1]), 32'd0);
    ctl[1] = 1'b1; wr(4'd0, 16'(ctl));
    wr(4'd4, 16'h0000);
    rd(4'd4, v); check("R6", "write 0 keeps", 32'(v), 32'd2);
    wr(4'd4, 16'h0002);
    rd(4'd4, v); check("R6", "write 1 clears", 32'(v), 32'd0);
    check("R8", "irq0 cleared", 32'(irq[0]), 32'd0);

    trial("R5", 0, 0, 0, 0, 4, 0, 0, 0, 13);
    check("R8", "irq0 disabled", 32'(irq[0]), 32'd0);
    trial("R5", 0, 0, 0, 0, 16, 16'hFFFE, 0, 0, 5);

    trial("R10", 1, 0, 1, 0, 1000, 0, 0, 0, 20);
    ctl[5] = 1'b1; wr(4'd0, 16'(ctl));
    rd(4'd11, v); check("R10", "at freeze", 32'(v), 32'd11);
    repeat (40) @(posedge clk);
    @(negedge clk);
    rd(4'd11, v); check("R10", "frozen", 32'(v), 32'd11);

    setup(0, 2'b01, 0, 0, 0, 0, 1, 0);
    start(0);
    repeat (3) @(posedge clk);
    wr(4'd4, 16'hFFFF);
    rd(4'd4, v); check("R7", "set wins", 32'(v), 32'd2);

    for (int k = 0; k < 20; k++) begin
      int t, p, s, r, c0, n;
      bit slow, rs;
      t    = int'($urandom % 2);
      slow = ($urandom % 4) == 0;
      p    = int'($urandom % 4);
      s    = int'($urandom % 4);
      r    = int'($urandom % 41);
      rs   = 1'($urandom % 2);
      c0   = rs ? int'($urandom % (r + 1)) : int'($urandom % 200);
      n    = 20 + int'($urandom % 381);
      trial(slow ? "R3" : "R2", t, slow, p, s, r, c0, rs, 0, n);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule